// File: doc/BRIEF.md
# Three-Phase Sine PWM Generator

This block drives a three-phase inverter bridge with one pulse-width-modulated bit per phase. A symmetric triangle carrier is compared against a sine-like power waveform. The waveform is held in an internal table that covers only a quarter cycle. Mirroring and sign inversion of that quarter give the full cycle of 1536 samples. The three phases read the cycle at points spaced one third of a cycle apart. A new waveform value is taken at every positive and every negative carrier peak, so the sampling is double-edged.

Control inputs set the carrier divider, the power-frequency range, a 12-bit speed word, the direction of rotation, an amplitude byte and an overmodulation bit. A run bit pins the phase at zero degrees. Setting the speed to zero freezes the phase, which gives a DC injection brake. Each phase also has a zero-phase marker for speed feedback. A sample-sync square wave follows the step through the table.

Top module: `tri_phase_spwm`

## Requirements
- R1: The carrier is a triangle of 512 steps. It counts 0 up to 255, holds 255 for one step, counts down to 0 and holds 0 for one step. The triangle advances once every n clocks, with n = 2^car_div_sel; codes 6 and 7 act as 32. A PWM period is therefore 512·n clocks.
- R2: Each phase has a 9-bit level L from 0 to 511. Its pwm bit is high on the triangle steps whose value is below L/2, integer division. With L = 256 the duty is 50%.
- R3: The levels change only at the two carrier peaks: the step at which the triangle turns at 255 and the step at which it turns at 0.
- R4: At each peak the phase advances by speed·2^range_sel/2048 samples, modulo 1536. Range codes 6 and 7 both mean 64. With speed = 0 the phase stays where it is.
- R5: Quarter-table entry k, for k from 0 to 383, holds floor(255·(k+1)·(767−k)/147456). For a sample index i, let r = i mod 768. The magnitude is entry r when r < 384 and entry 767−r otherwise. The sign is negative when i ≥ 768.
- R6: Let red be the phase index. Yellow reads index red−512 and blue reads red−1024, both modulo 1536.
- R7: With reverse = 1 the phase decreases instead of increasing, which reverses the order of the zero crossings. A change of direction takes effect at the next peak, from the current phase.
- R8: Let A = overmod·256 + amplitude and m = floor(magnitude·A/255). The level L is 256+m for a positive sample and 256−m for a negative one, clamped to the range 0 to 511.
- R9: While phase_run is 0, the phase is forced to 0 on every clock.
- R10: zero_phase[p] is high while the index of phase p is 1024 or more. Bits 0, 1 and 2 are red, yellow and blue. Each marker is high for a third of the power cycle and low for two thirds. In forward mode its falling edge marks 0°. In reverse mode its rising edge marks 0°.
- R11: sample_sync is the half-sample bit of the red phase: it is high during the second half of each sample step.
- R12: An active-low reset clears the carrier, the phase and all three pwm bits. While reset is held, pwm and sample_sync are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| car_div_sel | input | 3 | Carrier divider code |
| range_sel | input | 3 | Power-frequency range code |
| speed | input | 12 | Phase step per carrier peak |
| reverse | input | 1 | 1 = decreasing phase |
| amplitude | input | 8 | Amplitude scale |
| overmod | input | 1 | Amplitude ninth bit |
| phase_run | input | 1 | 0 = hold the phase at zero |
| pwm | output | 3 | PWM bits for red, yellow and blue |
| zero_phase | output | 3 | Zero-phase markers |
| sample_sync | output | 1 | Sample-step square wave |

## Verification
A pwm bit follows the triangle with one clock of delay. A new amplitude or phase reaches the level at the next peak, which is at most 256·n clocks away, so the bench waits more than a full carrier period before it measures a duty. Each duty is counted over exactly one carrier period, and the count does not depend on where that window starts. The zero-phase markers and sample_sync come straight from the phase register and change on the clock after a peak. Their periods and offsets are measured edge to edge in whole clocks: 256 clocks per peak at n = 1.

// File: rtl/tri_phase_spwm.sv
`timescale 1ns/1ps
module tri_phase_spwm #(
  parameter int PFS_W = 12,
  parameter int AMP_W = 8,
  parameter int QLEN  = 384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       car_div_sel,
  input  logic [2:0]       range_sel,
  input  logic [PFS_W-1:0] speed,
  input  logic             reverse,
  input  logic [AMP_W-1:0] amplitude,
  input  logic             overmod,
  input  logic             phase_run,
  output logic [2:0]       pwm,
  output logic [2:0]       zero_phase,
  output logic             sample_sync
);
  localparam int CYC    = 4 * QLEN;
  localparam int THIRD  = CYC / 3;
  localparam int IDX_W  = $clog2(CYC);
  localparam int QA_W   = $clog2(QLEN);
  localparam int FRAC_W = PFS_W - 1;
  localparam int PH_W   = IDX_W + FRAC_W;
  localparam int LVL_W  = AMP_W + 1;
  localparam int MAXV   = (1 << AMP_W) - 1;
  localparam int MID    = 1 << AMP_W;
  localparam logic [PH_W-1:0] FULL = PH_W'(CYC) << FRAC_W;

  function automatic logic [AMP_W-1:0] qtab(input int k);
    return AMP_W'((MAXV * (k + 1) * (2 * QLEN - 1 - k)) / (QLEN * QLEN));
  endfunction

  logic [AMP_W-1:0] qrom [QLEN];
  for (genvar k = 0; k < QLEN; k++) begin : g_rom
    assign qrom[k] = qtab(k);
  end

  logic [2:0] cs, rs;
  assign cs = (car_div_sel > 3'd5) ? 3'd5 : car_div_sel;
  assign rs = (range_sel > 3'd6) ? 3'd6 : range_sel;

  logic [4:0] pre_q, pre_max;
  logic [AMP_W-1:0] tri_q;
  logic up_q, tick, at_peak, samp;

  assign pre_max = (5'd1 << cs) - 5'd1;
  assign tick    = pre_q >= pre_max;
  assign at_peak = up_q ? (tri_q == '1) : (tri_q == '0);
  assign samp    = tick && at_peak;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      tri_q <= '0;
      up_q  <= 1'b1;
    end else begin
      pre_q <= tick ? '0 : pre_q + 5'd1;
      if (tick) begin
        if (at_peak)   up_q  <= !up_q;
        else if (up_q) tri_q <= tri_q + 1'b1;
        else           tri_q <= tri_q - 1'b1;
      end
    end
  end

  logic [PH_W-1:0] acc_q, inc, acc_fw, acc_bw;
  assign inc    = PH_W'(speed) << rs;
  assign acc_fw = (acc_q + inc >= FULL) ? acc_q + inc - FULL : acc_q + inc;
  assign acc_bw = (acc_q >= inc) ? acc_q - inc : acc_q + (FULL - inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc_q <= '0;
    else if (!phase_run) acc_q <= '0;
    else if (samp)       acc_q <= reverse ? acc_bw : acc_fw;
  end

  logic [IDX_W-1:0] idx;
  logic [LVL_W-1:0] amp9;
  assign idx         = acc_q[PH_W-1:FRAC_W];
  assign sample_sync = acc_q[FRAC_W-1];
  assign amp9        = {overmod, amplitude};

  logic [2:0][LVL_W-1:0] lvl_q, lvl_nx;

  for (genvar g = 0; g < 3; g++) begin : g_ph
    int p, r, mg, lv;
    logic neg;
    logic [QA_W-1:0] ti;
    always_comb begin
      p = int'(idx) + CYC - g * THIRD;
      if (p >= CYC) p = p - CYC;
      neg = (p >= 2 * QLEN);
      r   = neg ? p - 2 * QLEN : p;
      ti  = (r >= QLEN) ? QA_W'(2 * QLEN - 1 - r) : QA_W'(r);
      mg  = (int'(qrom[ti]) * int'(amp9)) / MAXV;
      lv  = neg ? MID - mg : MID + mg;
      if (lv < 0) lv = 0;
      if (lv > 2 * MID - 1) lv = 2 * MID - 1;
    end
    assign lvl_nx[g]     = LVL_W'(lv);
    assign zero_phase[g] = (p >= 2 * THIRD);
  end

  logic [2:0] pwm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= {3{LVL_W'(MID)}};
      pwm_q <= '0;
    end else begin
      if (samp) lvl_q <= lvl_nx;
      for (int g = 0; g < 3; g++) pwm_q[g] <= lvl_q[g][LVL_W-1:1] > tri_q;
    end
  end
  assign pwm = pwm_q;

  p_turn_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && up_q && tri_q == '1) |=> (!up_q && tri_q == '1));
  p_lvl_at_peak_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !samp |=> $stable(lvl_q));
  p_dc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_run && speed == '0) |=> $stable(acc_q));
  p_run_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_run |=> (acc_q == '0));
  p_one_marker_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(zero_phase) == 1);
  p_phase_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < FULL);
endmodule

// File: tb/tri_phase_spwm_tb.sv
`timescale 1ns/1ps
module tri_phase_spwm_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] car_div_sel, range_sel;
  logic [11:0] speed;
  logic reverse, overmod, phase_run;
  logic [7:0] amplitude;
  logic [2:0] pwm, zero_phase;
  logic sample_sync;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tri_phase_spwm u_dut (
    .clk(clk), .rst_n(rst_n), .car_div_sel(car_div_sel), .range_sel(range_sel),
    .speed(speed), .reverse(reverse), .amplitude(amplitude), .overmod(overmod),
    .phase_run(phase_run), .pwm(pwm), .zero_phase(zero_phase), .sample_sync(sample_sync)
  );

  localparam int VEC [5][2] = '{'{255, 0}, '{128, 0}, '{255, 1}, '{0, 0}, '{200, 1}};
  localparam int PIDX [3] = '{0, 1024, 512};

  function automatic int qv(int k);
    return (255 * (k + 1) * (767 - k)) / 147456;
  endfunction

  function automatic int exp_high(int i, int a);
    int r, b, m, lv;
    bit ng;
    ng = i >= 768;
    r  = ng ? i - 768 : i;
    b  = (r >= 384) ? qv(767 - r) : qv(r);
    m  = b * a / 255;
    lv = ng ? 256 - m : 256 + m;
    if (lv < 0) lv = 0;
    if (lv > 511) lv = 511;
    return 2 * (lv / 2);
  endfunction

  function automatic logic sigv(int s);
    if (s < 3) return pwm[s];
    else if (s < 6) return zero_phase[s - 3];
    else return sample_sync;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_edge(int s, logic e);
    logic prev, cur;
    prev = sigv(s);
    forever begin
      @(negedge clk);
      cur = sigv(s);
      if (cur == e && prev != e) break;
      prev = cur;
    end
  endtask

  task automatic count_to(int s, logic e, output int n);
    logic prev, cur;
    n = 0;
    prev = sigv(s);
    forever begin
      @(negedge clk);
      n++;
      cur = sigv(s);
      if (cur == e && prev != e) break;
      prev = cur;
    end
  endtask

  task automatic gap(int s1, logic e1, int s2, logic e2, output int n);
    wait_edge(s1, e1);
    count_to(s2, e2, n);
  endtask

  task automatic count_high(int s, int win, output int n);
    n = 0;
    repeat (win) begin
      @(negedge clk);
      if (sigv(s)) n++;
    end
  endtask

  task automatic count_marker_changes(int win, output int n);
    logic [2:0] prev;
    n = 0;
    prev = zero_phase;
    repeat (win) begin
      @(negedge clk);
      if (zero_phase != prev) n++;
      prev = zero_phase;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; car_div_sel = 3'd0; range_sel = 3'd0; speed = 12'd0;
    reverse = 1'b0; overmod = 1'b0; phase_run = 1'b0; amplitude = 8'd255;
    repeat (4) @(negedge clk);
    chk("R12 reset pwm", int'(pwm), 0);
    chk("R12 reset sample_sync", int'(sample_sync), 0);
    chk("R10 reset markers", int'(zero_phase), 2);
    rst_n = 1'b1;

    // R2 R5 R6 R8: phase held at 0, duty per phase for each amplitude vector
    foreach (VEC[v]) begin
      amplitude = 8'(VEC[v][0]);
      overmod   = VEC[v][1] != 0;
      repeat (1100) @(negedge clk);
      for (int ph = 0; ph < 3; ph++) begin
        count_high(ph, 512, n);
        chk($sformatf("R8 duty vec%0d phase%0d", v, ph), n, exp_high(PIDX[ph], VEC[v][1] * 256 + VEC[v][0]));
      end
    end

    // R1: carrier divider
    amplitude = 8'd0; overmod = 1'b0; car_div_sel = 3'd2;
    repeat (4200) @(negedge clk);
    count_high(0, 2048, n);
    chk("R1 R2 half duty n=4", n, 1024);
    gap(0, 1'b1, 0, 1'b1, n);
    chk("R1 period n=4", n, 2048);
    car_div_sel = 3'd7;
    gap(0, 1'b1, 0, 1'b1, n);
    chk("R1 period code7 as n=32", n, 16384);
    car_div_sel = 3'd0;
    repeat (600) @(negedge clk);

    // R4 R6 R10: running, 64 samples per peak, 24 peaks per cycle
    range_sel = 3'd6; speed = 12'd2048; phase_run = 1'b1;
    gap(3, 1'b0, 3, 1'b0, n);
    chk("R4 power period", n, 6144);
    gap(3, 1'b1, 3, 1'b0, n);
    chk("R10 marker high third", n, 2048);
    gap(3, 1'b0, 4, 1'b0, n);
    chk("R6 yellow lags red forward", n, 2048);

    // R7: reverse
    reverse = 1'b1;
    repeat (300) @(negedge clk);
    gap(3, 1'b1, 3, 1'b1, n);
    chk("R7 reverse period", n, 6144);
    gap(3, 1'b1, 5, 1'b1, n);
    chk("R7 blue follows red in reverse", n, 2048);
    reverse = 1'b0;
    wait_edge(3, 1'b0);
    reverse = 1'b1;
    count_to(3, 1'b1, n);
    chk("R7 continuity at direction change", n, 256);

    // R4: speed zero holds phase
    speed = 12'd0;
    repeat (300) @(negedge clk);
    count_marker_changes(7000, n);
    chk("R4 DC hold marker changes", n, 0);

    // R9: run low forces phase 0
    speed = 12'd2048; reverse = 1'b0;
    repeat (1000) @(negedge clk);
    phase_run = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 markers at zero phase", int'(zero_phase), 2);
    chk("R9 sample_sync at zero phase", int'(sample_sync), 0);

    // R11: half sample per peak
    range_sel = 3'd0; speed = 12'd1024; phase_run = 1'b1;
    gap(6, 1'b1, 6, 1'b1, n);
    chk("R11 sample_sync period", n, 512);
    gap(6, 1'b1, 6, 1'b0, n);
    chk("R11 sample_sync high half", n, 256);

    // R12: reset during operation
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12 pwm cleared", int'(pwm), 0);
    chk("R12 sample_sync cleared", int'(sample_sync), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule